// File: doc/BRIEF.md
# Pointer-Based Stuck-Cell Line Corrector

This block guards a single 512-bit memory line against cells that have failed permanently and hold a fixed value. It keeps a small bank of correction entries. Each entry holds a bit-position pointer and the one data bit that belongs at that position. Faults are not found with a syndrome code. After each line write, the block reads the array back at once, and every bit that differs from what was written is taken to be a stuck cell. Each such bit gets its own entry.

A client issues line reads and writes on the request port, and the block drives the raw array through a separate write/read port. On a read, every valid entry patches the raw line, and the corrected line is registered once before it is presented. The number of entries is a parameter, with a default of six. Entries are never released. If a fault is found while every entry is already taken, a sticky exhaustion flag is set and an overflow strobe is raised for one cycle.

Top module: `ecp_line_corrector`

## Requirements
- R1: After reset, reqReady is 1 and rdValid, wrDone, overflow and fullFlag are 0. A read of the line then returns the raw array contents unchanged.
- R2: When a write is accepted (reqValid and reqReady high at a clock edge with reqWrite=1), arrWrEn is high with arrWrData equal to the request data in the next cycle. arrRdEn is high in the cycle after that. The array returns arrRdData one cycle after arrRdEn.
- R3: When a read is accepted, arrRdEn is high in the next cycle. rdValid pulses for one cycle, three cycles after the accepting edge, with rdData holding the corrected line.
- R4: During write verification, each bit whose readback differs from the written data and that no valid entry already covers gets a new entry. While the faults do not exceed NUM_ENT, a later read returns exactly the last written line.
- R5: New entries are filled in ascending index order, one per cycle, and the lowest faulty bit position is served first. When new faults outnumber the free entries, the lowest positions are the ones covered.
- R6: Every write reloads the stored data bit of each valid entry from the new line. A read after that write returns the new value at each covered position.
- R7: If a new fault is found while all entries are in use, the write stops allocating. overflow is high for exactly one cycle, together with wrDone, and fullFlag goes to 1 and stays there until reset.
- R8: A write whose readback shows no uncovered mismatch finishes with a one-cycle wrDone and overflow at 0. This includes a write that only touches covered faults.
- R9: reqReady is 0 from the cycle after an accept until the operation completes. The array port is never written and read in the same cycle, and neither is active while reqReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = line write, 0 = line read |
| reqData | input | LINE_W | Line to be written |
| reqReady | output | 1 | Block idle and able to accept a request |
| rdValid | output | 1 | One-cycle strobe: rdData holds the corrected line |
| rdData | output | LINE_W | Corrected read line |
| wrDone | output | 1 | One-cycle strobe: write and verification finished |
| overflow | output | 1 | One-cycle strobe: a fault could not be given an entry |
| fullFlag | output | 1 | Sticky: entry bank exhausted |
| arrWrEn | output | 1 | Raw array line write strobe |
| arrWrData | output | LINE_W | Raw array write data |
| arrRdEn | output | 1 | Raw array line read strobe |
| arrRdData | input | LINE_W | Raw array read data, valid one cycle after arrRdEn |

## Verification
A corrupted entry pointer or a stale stored bit shows up only at the next read. It appears as a wrong bit at a stuck position in rdData, three cycles after that read is accepted. A wrong allocation count or a wrong free-entry decision shows up earlier, at the write's wrDone. There, overflow either fires when the bench model still expects a free entry or stays silent when it should fire. It also shows up at the following read, which exposes which positions were covered. The stimulus therefore puts stuck cells at both ends of the line and inside it, rewrites covered positions with both polarities, and exceeds the entry count, so that each kind of internal mistake reaches a port within one operation.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_PUT,
    ST_WR_CHK,
    ST_WR_CMP,
    ST_WR_FIX,
    ST_RD_GET,
    ST_RD_CAPT
  } ctrlStateT;

  // Strobes from control to the line datapath
  typedef struct packed {
    logic latchReq;   // capture request line
    logic captMism;   // capture verify mismatch vector
    logic allocOne;   // consume lowest mismatch into an entry
    logic setFull;    // abandon remaining mismatches, bank exhausted
    logic captRead;   // register corrected read line
  } pathStrobeT;

endpackage

// File: rtl/ecp_ctrl.sv
module ecp_ctrl
  import ecp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       mismAny,
  input  logic       freeAvail,
  output logic       reqReady,
  output logic       arrWrEn,
  output logic       arrRdEn,
  output logic       refreshRep,
  output pathStrobeT strobe,
  output logic       rdValid,
  output logic       wrDone,
  output logic       overflow
);

  ctrlStateT state, stateNext;
  logic      doneNow;

  always_comb begin
    stateNext  = state;
    strobe     = '0;
    refreshRep = 1'b0;
    doneNow    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          refreshRep      = reqWrite;
          stateNext       = reqWrite ? ST_WR_PUT : ST_RD_GET;
        end
      end
      ST_WR_PUT: stateNext = ST_WR_CHK;
      ST_WR_CHK: stateNext = ST_WR_CMP;
      ST_WR_CMP: begin
        strobe.captMism = 1'b1;
        stateNext       = ST_WR_FIX;
      end
      ST_WR_FIX: begin
        if (!mismAny) begin
          doneNow   = 1'b1;
          stateNext = ST_IDLE;
        end else if (freeAvail) begin
          strobe.allocOne = 1'b1;
        end else begin
          strobe.setFull = 1'b1;
          doneNow        = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      ST_RD_GET: stateNext = ST_RD_CAPT;
      ST_RD_CAPT: begin
        strobe.captRead = 1'b1;
        stateNext       = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign arrWrEn  = (state == ST_WR_PUT);
  assign arrRdEn  = (state == ST_WR_CHK) || (state == ST_RD_GET);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rdValid  <= 1'b0;
      wrDone   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      state    <= stateNext;
      rdValid  <= strobe.captRead;
      wrDone   <= doneNow;
      overflow <= strobe.setFull;
    end
  end

endmodule

// File: rtl/ecp_entry_bank.sv
module ecp_entry_bank #(
  parameter int LINE_W  = 512,
  parameter int NUM_ENT = 6,
  localparam int PTR_W  = $clog2(LINE_W),
  localparam int CNT_W  = $clog2(NUM_ENT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refreshRep,
  input  logic [LINE_W-1:0] refreshLine,
  input  logic              allocOne,
  input  logic [PTR_W-1:0]  allocPtr,
  input  logic              allocBit,
  input  logic              setFull,
  input  logic [LINE_W-1:0] rawLine,
  output logic [LINE_W-1:0] fixedLine,
  output logic [LINE_W-1:0] coverMask,
  output logic              freeAvail,
  output logic              fullFlag
);

  logic             entValid [NUM_ENT];
  logic [PTR_W-1:0] entPtr   [NUM_ENT];
  logic             entRep   [NUM_ENT];
  logic [CNT_W-1:0] useCnt;

  for (genvar g = 0; g < NUM_ENT; g++) begin : gEnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entValid[g] <= 1'b0;
        entPtr[g]   <= '0;
        entRep[g]   <= 1'b0;
      end else if (allocOne && (useCnt == CNT_W'(g))) begin
        entValid[g] <= 1'b1;
        entPtr[g]   <= allocPtr;
        entRep[g]   <= allocBit;
      end else if (refreshRep && entValid[g]) begin
        entRep[g]   <= refreshLine[entPtr[g]];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      useCnt   <= '0;
      fullFlag <= 1'b0;
    end else begin
      if (allocOne) useCnt <= useCnt + 1'b1;
      if (setFull) fullFlag <= 1'b1;
    end
  end

  assign freeAvail = (useCnt != CNT_W'(NUM_ENT));

  // Patch raw line; later entries are applied last and so win on a shared pointer
  always_comb begin
    fixedLine = rawLine;
    coverMask = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (entValid[i]) begin
        fixedLine[entPtr[i]] = entRep[i];
        coverMask[entPtr[i]] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ecp_line_path.sv
module ecp_line_path
  import ecp_pkg::*;
#(
  parameter int LINE_W = 512,
  localparam int PTR_W = $clog2(LINE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrobeT        strobe,
  input  logic [LINE_W-1:0] reqData,
  input  logic [LINE_W-1:0] arrRdData,
  input  logic [LINE_W-1:0] fixedLine,
  input  logic [LINE_W-1:0] coverMask,
  output logic [LINE_W-1:0] wLine,
  output logic [PTR_W-1:0]  allocPtr,
  output logic              allocBit,
  output logic              mismAny,
  output logic [LINE_W-1:0] rdData
);

  logic [LINE_W-1:0] mismVec;

  // Lowest set position of the pending mismatch vector
  always_comb begin
    allocPtr = '0;
    for (int b = LINE_W - 1; b >= 0; b--) begin
      if (mismVec[b]) allocPtr = PTR_W'(b);
    end
  end

  assign mismAny  = |mismVec;
  assign allocBit = wLine[allocPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wLine   <= '0;
      mismVec <= '0;
      rdData  <= '0;
    end else begin
      if (strobe.latchReq) wLine <= reqData;
      if (strobe.captMism) mismVec <= (arrRdData ^ wLine) & ~coverMask;
      else if (strobe.setFull) mismVec <= '0;
      else if (strobe.allocOne) mismVec[allocPtr] <= 1'b0;
      if (strobe.captRead) rdData <= fixedLine;
    end
  end

endmodule

// File: rtl/ecp_line_corrector.sv
module ecp_line_corrector
  import ecp_pkg::*;
#(
  parameter int LINE_W  = 512,
  parameter int NUM_ENT = 6,
  localparam int PTR_W  = $clog2(LINE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [LINE_W-1:0] reqData,
  output logic              reqReady,
  output logic              rdValid,
  output logic [LINE_W-1:0] rdData,
  output logic              wrDone,
  output logic              overflow,
  output logic              fullFlag,
  output logic              arrWrEn,
  output logic [LINE_W-1:0] arrWrData,
  output logic              arrRdEn,
  input  logic [LINE_W-1:0] arrRdData
);

  pathStrobeT        strobe;
  logic              refreshRep;
  logic              mismAny;
  logic              freeAvail;
  logic [PTR_W-1:0]  allocPtr;
  logic              allocBit;
  logic [LINE_W-1:0] fixedLine;
  logic [LINE_W-1:0] coverMask;
  logic [LINE_W-1:0] wLine;

  ecp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .mismAny    (mismAny),
    .freeAvail  (freeAvail),
    .reqReady   (reqReady),
    .arrWrEn    (arrWrEn),
    .arrRdEn    (arrRdEn),
    .refreshRep (refreshRep),
    .strobe     (strobe),
    .rdValid    (rdValid),
    .wrDone     (wrDone),
    .overflow   (overflow)
  );

  ecp_line_path #(.LINE_W(LINE_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqData   (reqData),
    .arrRdData (arrRdData),
    .fixedLine (fixedLine),
    .coverMask (coverMask),
    .wLine     (wLine),
    .allocPtr  (allocPtr),
    .allocBit  (allocBit),
    .mismAny   (mismAny),
    .rdData    (rdData)
  );

  ecp_entry_bank #(.LINE_W(LINE_W), .NUM_ENT(NUM_ENT)) u_bank (
    .clk         (clk),
    .rstN        (rstN),
    .refreshRep  (refreshRep),
    .refreshLine (reqData),
    .allocOne    (strobe.allocOne),
    .allocPtr    (allocPtr),
    .allocBit    (allocBit),
    .setFull     (strobe.setFull),
    .rawLine     (arrRdData),
    .fixedLine   (fixedLine),
    .coverMask   (coverMask),
    .freeAvail   (freeAvail),
    .fullFlag    (fullFlag)
  );

  assign arrWrData = wLine;

endmodule

// File: rtl/ecp_line_corrector_chk.sv
module ecp_line_corrector_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqWrite,
  input logic reqReady,
  input logic arrWrEn,
  input logic arrRdEn,
  input logic rdValid,
  input logic wrDone,
  input logic overflow,
  input logic fullFlag
);

  AST_WR_THEN_VERIFY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> arrWrEn ##1 arrRdEn);        // R2

  AST_RD_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> arrRdEn);                    // R3

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> ##2 rdValid);                // R3

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);                                                // R3

  AST_OVF_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> wrDone);                                                 // R7

  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> !overflow);                                              // R7

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |=> fullFlag);                                               // R7

  AST_FULL_AFTER_OVF: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> fullFlag);                                               // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |=> !wrDone);                                                  // R8

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({arrWrEn, arrRdEn, reqReady}));                              // R9

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);                                // R9

endmodule

bind ecp_line_corrector ecp_line_corrector_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqReady (reqReady),
  .arrWrEn  (arrWrEn),
  .arrRdEn  (arrRdEn),
  .rdValid  (rdValid),
  .wrDone   (wrDone),
  .overflow (overflow),
  .fullFlag (fullFlag)
);

// File: tb/ecp_line_corrector_tb.sv
module ecp_line_corrector_tb;

  localparam int LW = 512;
  localparam int NE = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [LW-1:0] reqData = '0;
  logic          reqReady, rdValid, wrDone, overflow, fullFlag, arrWrEn, arrRdEn;
  logic [LW-1:0] rdData, arrWrData;
  logic [LW-1:0] arrRdData = '0;

  // Array model with stuck cells
  logic [LW-1:0] mem = '0;
  logic [LW-1:0] stuckMask = '0;
  logic [LW-1:0] stuckVal = '0;

  // Bench reference state
  logic [LW-1:0] covered = '0;
  int            covCnt = 0;
  logic [LW-1:0] lastData = '0;
  logic          expFull = 1'b0;

  int errors = 0;
  int checks = 0;
  int cycle = 0;
  bit finished = 1'b0;

  logic [LW-1:0] rdQ [$];
  string         rdTag [$];
  int            rdAcc [$];
  logic          wrQ [$];

  always #2 clk = ~clk;   // 250 MHz

  always @(posedge clk) cycle <= cycle + 1;

  always @(posedge clk) begin
    if (arrWrEn) mem <= (arrWrData & ~stuckMask) | (stuckVal & stuckMask);
    if (arrRdEn) arrRdData <= mem;
  end

  ecp_line_corrector #(.LINE_W(LW), .NUM_ENT(NE)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqData(reqData), .reqReady(reqReady), .rdValid(rdValid), .rdData(rdData),
    .wrDone(wrDone), .overflow(overflow), .fullFlag(fullFlag),
    .arrWrEn(arrWrEn), .arrWrData(arrWrData), .arrRdEn(arrRdEn),
    .arrRdData(arrRdData)
  );

  task automatic check(input bit ok, input string tag, input logic [LW-1:0] act,
                       input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] expRead();
    logic [LW-1:0] bad;
    bad = stuckMask & ~covered;
    return (lastData & ~bad) | (stuckVal & bad);
  endfunction

  // Driver: write, updating the reference model (ascending-position allocation)
  task automatic doWrite(input logic [LW-1:0] d);
    logic [LW-1:0] newMism;
    logic          ovf;
    while (!reqReady) @(negedge clk);
    newMism = stuckMask & (d ^ stuckVal) & ~covered;
    ovf = 1'b0;
    for (int b = 0; b < LW; b++) begin
      if (newMism[b]) begin
        if (covCnt < NE) begin
          covered[b] = 1'b1;
          covCnt++;
        end else ovf = 1'b1;
      end
    end
    if (ovf) expFull = 1'b1;
    lastData = d;
    wrQ.push_back(ovf);
    reqValid = 1'b1; reqWrite = 1'b1; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R9 busy after write accept", LW'(reqReady), '0);
  endtask

  task automatic doRead(input string tag);
    while (!reqReady) @(negedge clk);
    rdQ.push_back(expRead());
    rdTag.push_back(tag);
    rdAcc.push_back(cycle);
    reqValid = 1'b1; reqWrite = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (rdValid) begin
        if (rdQ.size() == 0) check(1'b0, "R3 unexpected rdValid", '1, '0);
        else begin
          logic [LW-1:0] e;
          string t;
          int a;
          e = rdQ.pop_front(); t = rdTag.pop_front(); a = rdAcc.pop_front();
          check(rdData == e, t, rdData, e);
          check(cycle - a == 3, "R3 read latency", LW'(cycle - a), LW'(3));
        end
      end
      if (wrDone) begin
        if (wrQ.size() == 0) check(1'b0, "R8 unexpected wrDone", '1, '0);
        else begin
          logic eo;
          eo = wrQ.pop_front();
          check(overflow == eo, eo ? "R7 overflow expected" : "R8 no overflow expected",
                LW'(overflow), LW'(eo));
          check(fullFlag == expFull, "R7 full flag", LW'(fullFlag), LW'(expFull));
        end
      end else if (overflow) check(1'b0, "R7 overflow without wrDone", '1, '0);
      if (arrWrEn && arrRdEn) check(1'b0, "R9 array port conflict", '1, '0);
    end
  end

  function automatic logic [LW-1:0] randLine();
    logic [LW-1:0] v;
    for (int k = 0; k < LW / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic drain();
    while (rdQ.size() != 0 || wrQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [LW-1:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1 reqReady", LW'(reqReady), LW'(1));
    check({rdValid, wrDone, overflow, fullFlag} == 4'b0, "R1 strobes low",
          LW'({rdValid, wrDone, overflow, fullFlag}), '0);
    rstN = 1'b1;
    @(negedge clk);
    doRead("R1 read after reset");
    drain();

    // R2/R4/R8 fault-free patterns
    doWrite('1);                 doRead("R4 all ones");
    doWrite({(LW/2){2'b10}});    doRead("R4 alternating");
    doWrite(randLine());         doRead("R4 random line");
    drain();

    // R4/R5 three stuck cells at both ends and inside
    stuckMask[0] = 1'b1;   stuckVal[0] = 1'b1;
    stuckMask[511] = 1'b1; stuckVal[511] = 1'b0;
    stuckMask[200] = 1'b1; stuckVal[200] = 1'b0;
    d = '1; d[0] = 1'b0;
    doWrite(d);                  doRead("R4 three faults corrected");
    drain();
    check(covCnt == 3, "R5 model count", LW'(covCnt), LW'(3));

    // R6 refresh of covered bits: both polarities
    d = '0;                      doWrite(d); doRead("R6 covered bits reloaded to zero");
    d = '1; d[0] = 1'b0; d[200] = 1'b1;
    doWrite(d);                  doRead("R6 covered bits reloaded to one");
    doWrite(randLine());         doRead("R6 random over covered faults");
    drain();

    // R5/R7 four new faults, three free entries: lowest positions win
    stuckMask[50] = 1'b1;  stuckVal[50] = 1'b0;
    stuckMask[100] = 1'b1; stuckVal[100] = 1'b0;
    stuckMask[300] = 1'b1; stuckVal[300] = 1'b0;
    stuckMask[400] = 1'b1; stuckVal[400] = 1'b0;
    d = '1;
    doWrite(d);                  doRead("R5 lowest three covered, bit 400 uncovered");
    drain();
    check(fullFlag == 1'b1, "R7 full flag held", LW'(fullFlag), LW'(1));

    // R8 write matching the uncovered stuck value: no overflow
    d = randLine(); d[400] = 1'b0;
    doWrite(d);                  doRead("R8 clean write after exhaustion");
    // R7 again with the uncovered cell in conflict
    d[400] = 1'b1;
    doWrite(d);                  doRead("R7 uncovered fault visible");
    drain();
    check(fullFlag == 1'b1, "R7 full flag sticky", LW'(fullFlag), LW'(1));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule